// File: doc/BRIEF.md
# RTC Status and Initialization Controller

This block keeps the control and status flags of a real-time clock calendar behind one 8-bit bus register. Software reads the register to see the flags. It writes the register to request initialization mode and to clear the sticky flags. A flag is cleared by writing 0 to its bit, and writing 1 to it leaves it as it is.

The calendar counters, prescaler, alarm comparators and sub-second shift arithmetic all sit outside the block. The block talks to them through strobes and enables:
- `count_en` freezes the counters.
- `cal_load` gates writes of new time, date and prescaler values.
- `shadow_copy` asks for a copy of the live calendar into the shadow registers.
- Match inputs and a shift-done input bring back the external events.

The initialization request needs an acknowledge. The acknowledge bit rises only after a fixed number of RTC ticks, and new calendar values are accepted only while that bit is 1.

Top module: `rtc_ctl_status`

## Requirements
- R1: After reset every register bit reads 0 and `count_en` is 1.
- R2: An alarm match input (`alm_a_match`, `alm_b_match`) that is high at a clock edge sets its flag (bit 5 for alarm A, bit 6 for alarm B), and the flag reads 1 from that edge on.
- R3: A register write with 0 in an alarm flag bit clears that flag. Writing 1 leaves it unchanged. A match in the same cycle as a clearing write wins, so the flag stays 1.
- R4: Bit 0 is the init request. It is loaded from `reg_wdata[0]` on every register write. While it is 1, `count_en` is 0.
- R5: The init acknowledge (bit 1) rises at the edge where the INIT_DLY-th `tick` is seen after the edge that set the init request (default 2). It falls on the same edge that clears the init request.
- R6: `cal_load` equals `cal_wr` while the init acknowledge is 1, and is 0 otherwise.
- R7: `shadow_copy` equals `tick` when the init request, shift pending and `bypass` are all 0, and is 0 otherwise. Each copy sets the sync flag (bit 2) at that edge.
- R8: The sync flag is cleared at the next edge while the registered init request, shift pending or `bypass` is 1. A register write with 0 in bit 2 also clears it, unless a copy occurs in the same cycle.
- R9: Bit 3 reads 1 exactly when the `year` input is nonzero, with no delay.
- R10: Shift pending (bit 4) is set by `shift_wr` and cleared by `shift_done`. `shift_wr` is ignored while the flag is already 1, `shift_done` is ignored while it is 0, and register writes never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register readback |
| tick | input | 1 | RTC clock tick enable |
| bypass | input | 1 | Shadow bypass mode |
| alm_a_match | input | 1 | Calendar equals alarm A |
| alm_b_match | input | 1 | Calendar equals alarm B |
| shift_wr | input | 1 | Software wrote the shift register |
| shift_done | input | 1 | External shift logic finished |
| cal_wr | input | 1 | Write attempt to time/date/prescaler |
| year | input | YEAR_W | Current calendar year field |
| count_en | output | 1 | Calendar and prescaler counters may run |
| cal_load | output | 1 | Accepted time/date/prescaler write |
| shadow_copy | output | 1 | Copy live calendar into shadow registers |

## Verification
The assertions assume that every input is synchronous to `clk` and is sampled only at rising edges. They also assume that the match, shift and tick strobes carry meaning in any cycle, including back-to-back cycles. The shift and sync properties therefore do not rely on any spacing between events. The bench changes inputs only on falling edges, so each value is stable across the edge that samples it. It covers the cases the assertions leave open: a match together with a clearing write, `shift_wr` together with `shift_done` while idle, and ticks during initialization.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;
    localparam int REG_W    = 8;
    localparam int B_INIT   = 0;
    localparam int B_ACK    = 1;
    localparam int B_SYNC   = 2;
    localparam int B_CALSET = 3;
    localparam int B_SHIFT  = 4;
    localparam int B_ALMA   = 5;
    localparam int N_ALARM  = 2;

    typedef struct packed {
        logic init_req;
        logic sync;
        logic shift_pend;
    } ctl_state_t;
endpackage

// File: rtl/rtc_w0c_flag.sv
module rtc_w0c_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // hardware set wins over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/rtc_init_hs.sv
module rtc_init_hs #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_next,
    input  logic req_held,
    input  logic tick,
    output logic ack_o
);
    localparam int CNT_W = $clog2(DLY + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ack;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d = hs_q;
        if (!req_next) begin
            hs_d.cnt = '0;
            hs_d.ack = 1'b0;
        end else if (req_held && !hs_q.ack && tick) begin
            if (hs_q.cnt == CNT_W'(DLY - 1)) begin
                hs_d.ack = 1'b1;
                hs_d.cnt = '0;
            end else begin
                hs_d.cnt = hs_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign ack_o = hs_q.ack;
endmodule

// File: rtl/rtc_ctl_status.sv
module rtc_ctl_status
    import rtc_ctl_pkg::*;
#(
    parameter int INIT_DLY = 2,
    parameter int YEAR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              tick,
    input  logic              bypass,
    input  logic              alm_a_match,
    input  logic              alm_b_match,
    input  logic              shift_wr,
    input  logic              shift_done,
    input  logic              cal_wr,
    input  logic [YEAR_W-1:0] year,
    output logic              count_en,
    output logic              cal_load,
    output logic              shadow_copy
);
    ctl_state_t st_d, st_q;
    logic       ack;
    logic [N_ALARM-1:0] alm_match, alm_flag;

    assign alm_match = {alm_b_match, alm_a_match};

    always_comb begin
        st_d        = st_q;
        shadow_copy = tick & ~st_q.init_req & ~st_q.shift_pend & ~bypass;

        if (reg_wr) st_d.init_req = reg_wdata[B_INIT];

        if (st_q.init_req || st_q.shift_pend || bypass)
            st_d.sync = 1'b0;
        else if (shadow_copy)
            st_d.sync = 1'b1;
        else if (reg_wr && !reg_wdata[B_SYNC])
            st_d.sync = 1'b0;

        if (st_q.shift_pend) st_d.shift_pend = ~shift_done;
        else                 st_d.shift_pend = shift_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rtc_init_hs #(.DLY(INIT_DLY)) u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_next (st_d.init_req),
        .req_held (st_q.init_req),
        .tick     (tick),
        .ack_o    (ack)
    );

    for (genvar g = 0; g < N_ALARM; g++) begin : g_alarm
        rtc_w0c_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (alm_match[g]),
            .clr_i  (reg_wr & ~reg_wdata[B_ALMA+g]),
            .flag_o (alm_flag[g])
        );
    end

    assign count_en = ~st_q.init_req;
    assign cal_load = cal_wr & ack;

    always_comb begin
        reg_rdata           = '0;
        reg_rdata[B_INIT]   = st_q.init_req;
        reg_rdata[B_ACK]    = ack;
        reg_rdata[B_SYNC]   = st_q.sync;
        reg_rdata[B_CALSET] = |year;
        reg_rdata[B_SHIFT]  = st_q.shift_pend;
        for (int i = 0; i < N_ALARM; i++)
            reg_rdata[B_ALMA+i] = alm_flag[i];
    end
endmodule

// File: rtl/rtc_ctl_status_chk.sv
module rtc_ctl_status_chk
    import rtc_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] reg_rdata,
    input logic             bypass,
    input logic             alm_a_match,
    input logic             alm_b_match,
    input logic             shift_done,
    input logic             count_en,
    input logic             cal_load,
    input logic             shadow_copy
);
    a_r2_alarm_a_set: assert property (@(posedge clk) disable iff (!rst_n)
        alm_a_match |=> reg_rdata[B_ALMA]);

    a_r2_alarm_b_set: assert property (@(posedge clk) disable iff (!rst_n)
        alm_b_match |=> reg_rdata[B_ALMA+1]);

    a_r4_frozen_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[B_INIT]) |-> !count_en);

    a_r5_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[B_ACK] |-> reg_rdata[B_INIT]);

    a_r5_ack_drops_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[B_INIT]) |-> !reg_rdata[B_ACK]);

    a_r6_load_only_acked: assert property (@(posedge clk) disable iff (!rst_n)
        cal_load |-> reg_rdata[B_ACK]);

    a_r7_copy_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[B_INIT] || reg_rdata[B_SHIFT] || bypass) |-> !shadow_copy);

    a_r8_bypass_clears_sync: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> !reg_rdata[B_SYNC]);

    a_r10_shift_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[B_SHIFT] && !shift_done) |=> reg_rdata[B_SHIFT]);
endmodule

bind rtc_ctl_status rtc_ctl_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rdata   (reg_rdata),
    .bypass      (bypass),
    .alm_a_match (alm_a_match),
    .alm_b_match (alm_b_match),
    .shift_done  (shift_done),
    .count_en    (count_en),
    .cal_load    (cal_load),
    .shadow_copy (shadow_copy)
);

// File: tb/sim_rtc_ctl_status.sv
module sim_rtc_ctl_status;
    localparam time CLK_P = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tick = 1'b0, bypass = 1'b0, alm_a_match = 1'b0, alm_b_match = 1'b0;
    logic       shift_wr = 1'b0, shift_done = 1'b0, cal_wr = 1'b0;
    logic [7:0] year = '0;
    logic       count_en, cal_load, shadow_copy;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    rtc_ctl_status u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tick(tick), .bypass(bypass),
        .alm_a_match(alm_a_match), .alm_b_match(alm_b_match),
        .shift_wr(shift_wr), .shift_done(shift_done), .cal_wr(cal_wr),
        .year(year), .count_en(count_en), .cal_load(cal_load),
        .shadow_copy(shadow_copy)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] wd;
        logic       ma, mb, sw, sd, byp, tk;
        logic [7:0] yr;
        logic [7:0] ex;
    } vec_t;

    localparam int NV = 23;
    // wr, wdata, matchA, matchB, shift_wr, shift_done, bypass, tick, year, expected rdata
    localparam vec_t TBL [NV] = '{
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h20}, // R2
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h60}, // R2
        '{1'b1, 8'hFE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h60}, // R3 write 1
        '{1'b1, 8'hDE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h40}, // R3 clear A
        '{1'b1, 8'hBE, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h40}, // R3 set wins
        '{1'b1, 8'hBE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00}, // R3 clear B
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 8'h08}, // R9
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h10}, // R10 set
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h10}, // R10 ignored
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h10}, // R10 bus write
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h10}, // R7 blocked
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00}, // R10 done
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h04}, // R7 copy
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00}, // R8 bypass
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00}, // R7 bypass
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h04}, // R7
        '{1'b1, 8'hFA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00}, // R8 sw clear
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h04}, // R7
        '{1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h01}, // R4 init
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h01}, // R5 tick 1
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h01}, // R5 no tick
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h03}, // R5 ack
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00}  // R5 drop
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 0; reg_wdata = '0; tick = 0; bypass = 0; alm_a_match = 0;
        alm_b_match = 0; shift_wr = 0; shift_done = 0; cal_wr = 0; year = '0;
    endtask

    task automatic edge_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset rdata", reg_rdata, 8'h00);
        chk("R1 reset count_en", {7'd0, count_en}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            reg_wr = TBL[i].wr; reg_wdata = TBL[i].wd;
            alm_a_match = TBL[i].ma; alm_b_match = TBL[i].mb;
            shift_wr = TBL[i].sw; shift_done = TBL[i].sd;
            bypass = TBL[i].byp; tick = TBL[i].tk; year = TBL[i].yr;
            edge_step();
            chk($sformatf("R2 R3 R5 R7 R8 R9 R10 table row %0d", i), reg_rdata, TBL[i].ex);
        end
        idle();

        // R7: copy strobe follows tick when unblocked
        tick = 1; #1;
        chk("R7 copy strobe", {7'd0, shadow_copy}, 8'h01);
        edge_step();
        chk("R7 sync set", reg_rdata, 8'h04);
        bypass = 1; #1;
        chk("R7 bypass blocks copy", {7'd0, shadow_copy}, 8'h00);
        idle(); edge_step();

        // R8: init clears sync one edge after the request registers
        tick = 1; edge_step(); idle();
        reg_wr = 1; reg_wdata = 8'h05; edge_step(); idle();
        chk("R8 sync before init seen", reg_rdata, 8'h05);
        chk("R4 counters frozen", {7'd0, count_en}, 8'h00);
        edge_step();
        chk("R8 init clears sync", reg_rdata, 8'h01);

        // R6/R5: loads rejected until ack, then accepted
        tick = 1; cal_wr = 1; #1;
        chk("R6 load rejected", {7'd0, cal_load}, 8'h00);
        chk("R7 no copy in init", {7'd0, shadow_copy}, 8'h00);
        edge_step();
        chk("R5 ack not yet", reg_rdata, 8'h01);
        edge_step();
        chk("R5 ack after two ticks", reg_rdata, 8'h03);
        chk("R6 load accepted", {7'd0, cal_load}, 8'h01);
        idle();
        reg_wr = 1; reg_wdata = 8'h00; edge_step(); idle();
        chk("R5 ack falls with request", reg_rdata, 8'h00);
        chk("R4 counters run", {7'd0, count_en}, 8'h01);

        // R10: done ignored while idle, bus write has no effect
        shift_wr = 1; shift_done = 1; edge_step(); idle();
        chk("R10 set with stray done", reg_rdata, 8'h10);
        shift_done = 1; edge_step(); idle();
        chk("R10 cleared by done", reg_rdata, 8'h00);
        reg_wr = 1; reg_wdata = 8'h10; edge_step(); idle();
        chk("R10 bus write ignored", reg_rdata, 8'h00);

        // R9: top year bit alone
        year = 8'h80; #1;
        chk("R9 year nonzero", reg_rdata, 8'h08);
        idle();

        // R1: reset in mid-run
        alm_b_match = 1; edge_step(); idle();
        chk("R2 alarm B set", reg_rdata, 8'h40);
        rst_n = 0; #1;
        chk("R1 async reset", reg_rdata, 8'h00);
        @(negedge clk); rst_n = 1; @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule